// File: doc/BRIEF.md
# Match-Compare Operating-System Timer with Watchdog Reset

This block keeps a 32-bit up-counter that advances by one on every clock cycle in which a tick-enable input is high. It also holds four 32-bit compare registers. Each time a tick moves the counter onto the value held in a compare register, that channel produces a match event. If the channel's bit in the interrupt-enable register is set, the event latches a status bit, and that status bit drives the channel's interrupt line. Software clears a status bit by writing a 1 to it. The highest channel can also act as a watchdog: once the watchdog-enable bit has been set, a match on that channel raises a reset request that stays high until system reset.

Software reaches the block through a plain word-wide register port with byte addresses. The port accepts every write and every read in the cycle it is presented, so it never applies back-pressure. Read data appears on the next clock with a one-cycle valid strobe. The returned value is the register contents as they stood before the edge that accepted the read. A request must not carry read and write together.

Top module: `ostmr_top`

## Requirements
- R1: The counter (byte offset 0x10) rises by exactly one at each clock edge where `tick_en_i` is high and no counter write is made. It holds its value when `tick_en_i` is low.
- R2: A write to offset 0x10 loads the counter, and counting continues from the loaded value. If a tick falls in the same cycle, the load wins. The load itself produces no match event.
- R3: Compare register i is at offset 4*i (0x00, 0x04, 0x08, 0x0C). A match event for channel i occurs on the edge where a tick moves the counter onto a value equal to compare register i. Status bit i (offset 0x14, bit i) is set by that event only if enable bit i (offset 0x1C, bit i) was 1 before the edge.
- R4: `irq_o[i]` is high exactly when status bit i is set.
- R5: Writing offset 0x14 clears every status bit whose data bit is 1 and leaves bits written with 0 unchanged. If a qualified match event on a channel arrives in the same cycle as a clear of that bit, the bit stays set.
- R6: The enable register keeps data bits 11:0. Bits 31:12 read back as zero.
- R7: Matching compares all 32 bits, so the counter wraps from 0xFFFFFFFF to 0 and a compare value past the wrap still fires.
- R8: Writing 1 to bit 0 of offset 0x18 sets the watchdog-enable bit. Writing 0 has no effect. Only reset clears it. It reads back in bit 0.
- R9: `wdt_rst_o` rises on the edge where channel 3 has a match event while the watchdog-enable bit is set, whatever enable bit 3 holds. It then stays high until reset.
- R10: `bus_rvalid_o` goes high in the cycle after a read request. `bus_rdata_o` then holds the pre-edge value. Unmapped offsets read as zero and ignore writes. After reset, every register, `irq_o` and `wdt_rst_o` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_en_i | input | 1 | Counter advance enable, one count per high cycle |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 8 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid with bus_rvalid_o |
| bus_rvalid_o | output | 1 | Read data valid, one cycle after bus_rd_i |
| irq_o | output | 4 | Per-channel interrupt, equal to the status bits |
| wdt_rst_o | output | 1 | Watchdog reset request, sticky until reset |

## Verification
Two pairs of functions can fall in the same cycle: a status clear meeting a fresh match event on the same channel, and a counter load meeting a tick. The bench sets up each collision on purpose by placing a compare value one count ahead, then driving the clear or the load on the cycle the tick arrives. It expects the status bit to survive and the loaded value to win. A long random phase then mixes small counter loads, compare writes, clears and reads with an irregular tick. A behavioural model scores every cycle, so these overlaps also occur in many unplanned phase relations.

// File: rtl/ostmr_pkg.sv
`timescale 1ns/1ps
package ostmr_pkg;
  localparam int unsigned OFS_CNT  = 'h10;
  localparam int unsigned OFS_STAT = 'h14;
  localparam int unsigned OFS_WD   = 'h18;
  localparam int unsigned OFS_EN   = 'h1C;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_MATCH,
    SEL_CNT,
    SEL_STAT,
    SEL_WD,
    SEL_EN
  } reg_sel_e;
endpackage

// File: rtl/ostmr_counter.sv
`timescale 1ns/1ps
module ostmr_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] step_o,
  output logic         adv_o
);
  logic [W-1:0] cnt_q;

  assign step_o = cnt_q + W'(1);
  assign adv_o  = tick_i && !load_i;
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (tick_i) cnt_q <= step_o;
  end

  // R1: one step per tick, modulo 2^W
  a_r1_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !load_i) |=> (cnt_q == W'($past(cnt_q) + W'(1))));
  a_r1_count_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !load_i) |=> $stable(cnt_q));
  // R2: load beats tick
  a_r2_load_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == $past(load_val_i)));
endmodule

// File: rtl/ostmr_chan.sv
`timescale 1ns/1ps
module ostmr_chan #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         adv_i,
  input  logic [W-1:0] step_i,
  output logic [W-1:0] match_o,
  output logic         hit_o
);
  logic [W-1:0] match_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   match_q <= '0;
    else if (wr_i) match_q <= wdata_i;
  end

  assign match_o = match_q;
  // event only when a tick carries the counter onto the compare value
  assign hit_o   = adv_i && (step_i == match_q);

  // R3: compare value only changes through its own write
  a_r3_match_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(match_q));
  a_r3_match_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (match_q == $past(wdata_i)));
endmodule

// File: rtl/ostmr_regs.sv
`timescale 1ns/1ps
module ostmr_regs import ostmr_pkg::*; #(
  parameter int unsigned W      = 32,
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned EN_W   = 12,
  parameter int unsigned WD_CH  = NUM_CH - 1,
  localparam int unsigned IDX_W = $clog2(NUM_CH)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       clr_wr_i,
  input  logic [NUM_CH-1:0]          clr_mask_i,
  input  logic                       en_wr_i,
  input  logic [EN_W-1:0]            en_val_i,
  input  logic                       wd_wr_i,
  input  logic                       wd_bit_i,
  input  logic [NUM_CH-1:0]          hit_i,
  input  logic                       rd_i,
  input  reg_sel_e                   rsel_i,
  input  logic [IDX_W-1:0]           ridx_i,
  input  logic [W-1:0]               cnt_i,
  input  logic [NUM_CH-1:0][W-1:0]   match_i,
  output logic [NUM_CH-1:0]          stat_o,
  output logic                       wdt_o,
  output logic [W-1:0]               rdata_o,
  output logic                       rvalid_o
);
  logic [NUM_CH-1:0] stat_q, stat_d, qual_hit, clr_eff;
  logic [EN_W-1:0]   en_q;
  logic              wd_q, wdt_q, rvalid_q;
  logic [W-1:0]      rdata_q, rmux;

  assign qual_hit = hit_i & en_q[NUM_CH-1:0];
  assign clr_eff  = clr_wr_i ? clr_mask_i : '0;
  // a new qualified event overrides a clear in the same cycle
  assign stat_d   = (stat_q & ~clr_eff) | qual_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      en_q   <= '0;
      wd_q   <= 1'b0;
      wdt_q  <= 1'b0;
    end else begin
      stat_q <= stat_d;
      if (en_wr_i) en_q <= en_val_i;
      if (wd_wr_i && wd_bit_i) wd_q <= 1'b1;
      if (hit_i[WD_CH] && wd_q) wdt_q <= 1'b1;
    end
  end

  always_comb begin
    case (rsel_i)
      SEL_MATCH: rmux = match_i[ridx_i];
      SEL_CNT:   rmux = cnt_i;
      SEL_STAT:  rmux = {{(W-NUM_CH){1'b0}}, stat_q};
      SEL_WD:    rmux = {{(W-1){1'b0}}, wd_q};
      SEL_EN:    rmux = {{(W-EN_W){1'b0}}, en_q};
      default:   rmux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= rd_i;
      if (rd_i) rdata_q <= rmux;
    end
  end

  assign stat_o   = stat_q;
  assign wdt_o    = wdt_q;
  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;

  // R3: no status bit rises without its enable
  a_r3_enable_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(en_q[NUM_CH-1:0])) == '0));
  // R5: cleared bits drop unless a new event arrives
  a_r5_w1c: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_wr_i && |(clr_mask_i & ~hit_i)) |=> ((stat_q & $past(clr_mask_i & ~hit_i)) == '0));
  // R5: a qualified event always lands
  a_r5_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|qual_hit) |=> ((stat_q & $past(qual_hit)) == $past(qual_hit)));
  // R8: watchdog enable is sticky
  a_r8_wd_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_q |=> wd_q);
  // R9: reset request is sticky and has a cause
  a_r9_wdt_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_q |=> wdt_q);
  a_r9_wdt_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wdt_q && !(hit_i[WD_CH] && wd_q)) |=> !wdt_q);
  // R10: read strobe timing
  a_r10_rvalid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> rvalid_q);
  a_r10_no_rvalid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> !rvalid_q);
endmodule

// File: rtl/ostmr_top.sv
`timescale 1ns/1ps
module ostmr_top import ostmr_pkg::*; #(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned EN_W   = 12,
  parameter int unsigned ADDR_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_en_i,
  input  logic                bus_wr_i,
  input  logic                bus_rd_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic [CNT_W-1:0]    bus_wdata_i,
  output logic [CNT_W-1:0]    bus_rdata_o,
  output logic                bus_rvalid_o,
  output logic [NUM_CH-1:0]   irq_o,
  output logic                wdt_rst_o
);
  localparam int unsigned IDX_W  = $clog2(NUM_CH);
  localparam int unsigned WORD_W = ADDR_W - 2;
  localparam int unsigned WD_CH  = NUM_CH - 1;

  logic [WORD_W-1:0] word;
  logic              aligned, is_match;
  logic [IDX_W-1:0]  ch_idx;
  reg_sel_e          sel;

  assign word     = bus_addr_i[ADDR_W-1:2];
  assign aligned  = (bus_addr_i[1:0] == 2'b00);
  assign is_match = aligned && (word < WORD_W'(NUM_CH));
  assign ch_idx   = word[IDX_W-1:0];

  always_comb begin
    sel = SEL_NONE;
    if (is_match)                           sel = SEL_MATCH;
    else if (bus_addr_i == ADDR_W'(OFS_CNT))  sel = SEL_CNT;
    else if (bus_addr_i == ADDR_W'(OFS_STAT)) sel = SEL_STAT;
    else if (bus_addr_i == ADDR_W'(OFS_WD))   sel = SEL_WD;
    else if (bus_addr_i == ADDR_W'(OFS_EN))   sel = SEL_EN;
  end

  logic                     cnt_load, adv;
  logic [CNT_W-1:0]         cnt, step;
  logic [NUM_CH-1:0]        hit;
  logic [NUM_CH-1:0][CNT_W-1:0] match_vals;

  assign cnt_load = bus_wr_i && (sel == SEL_CNT);

  ostmr_counter #(.W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_en_i),
    .load_i     (cnt_load),
    .load_val_i (bus_wdata_i),
    .cnt_o      (cnt),
    .step_o     (step),
    .adv_o      (adv)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic ch_wr;
    assign ch_wr = bus_wr_i && (sel == SEL_MATCH) && (ch_idx == IDX_W'(i));
    ostmr_chan #(.W(CNT_W)) u_chan (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (ch_wr),
      .wdata_i (bus_wdata_i),
      .adv_i   (adv),
      .step_i  (step),
      .match_o (match_vals[i]),
      .hit_o   (hit[i])
    );
  end

  ostmr_regs #(
    .W(CNT_W), .NUM_CH(NUM_CH), .EN_W(EN_W), .WD_CH(WD_CH)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_wr_i   (bus_wr_i && (sel == SEL_STAT)),
    .clr_mask_i (bus_wdata_i[NUM_CH-1:0]),
    .en_wr_i    (bus_wr_i && (sel == SEL_EN)),
    .en_val_i   (bus_wdata_i[EN_W-1:0]),
    .wd_wr_i    (bus_wr_i && (sel == SEL_WD)),
    .wd_bit_i   (bus_wdata_i[0]),
    .hit_i      (hit),
    .rd_i       (bus_rd_i),
    .rsel_i     (sel),
    .ridx_i     (ch_idx),
    .cnt_i      (cnt),
    .match_i    (match_vals),
    .stat_o     (irq_o),
    .wdt_o      (wdt_rst_o),
    .rdata_o    (bus_rdata_o),
    .rvalid_o   (bus_rvalid_o)
  );

  // R2: a load never produces a match event
  a_r2_load_no_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_load |-> (hit == '0));
endmodule

// File: tb/sim_ostmr_top.sv
`timescale 1ns/1ps
module sim_ostmr_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick, wr, rd;
  logic [7:0]  addr;
  logic [31:0] wdata, rdata;
  logic        rvalid, wdt;
  logic [3:0]  irq;

  int n_checks = 0;
  int n_err    = 0;
  int cyc      = 0;

  always #2.5 clk = ~clk;

  ostmr_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_en_i(tick), .bus_wr_i(wr), .bus_rd_i(rd),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .bus_rvalid_o(rvalid), .irq_o(irq), .wdt_rst_o(wdt)
  );

  // behavioural reference model
  logic [31:0] m_cnt, m_nxt, m_rdata;
  logic [31:0] m_match [4];
  logic [3:0]  m_stat, m_hits;
  logic [11:0] m_en;
  logic        m_wd, m_wdt, m_rvalid, m_ld, m_adv;
  logic [7:0]  m_raddr;

  function automatic logic [31:0] mread(input logic [7:0] a);
    case (a)
      8'h00, 8'h04, 8'h08, 8'h0C: return m_match[a[3:2]];
      8'h10: return m_cnt;
      8'h14: return {28'b0, m_stat};
      8'h18: return {31'b0, m_wd};
      8'h1C: return {20'b0, m_en};
      default: return 32'b0;
    endcase
  endfunction

  function automatic string rtag(input logic [7:0] a);
    case (a)
      8'h00, 8'h04, 8'h08, 8'h0C: return "R3";
      8'h10: return "R1";
      8'h14: return "R5";
      8'h18: return "R8";
      8'h1C: return "R6";
      default: return "R10";
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_stat = 0; m_en = 0; m_wd = 0; m_wdt = 0;
      m_rvalid = 0; m_rdata = 0; m_raddr = 0;
      for (int i = 0; i < 4; i++) m_match[i] = 0;
    end else begin
      m_ld  = wr && (addr == 8'h10);
      m_adv = tick && !m_ld;
      m_nxt = m_cnt + 32'd1;
      for (int i = 0; i < 4; i++) m_hits[i] = m_adv && (m_nxt == m_match[i]);
      m_rvalid = rd;
      if (rd) begin m_rdata = mread(addr); m_raddr = addr; end
      if (wr && addr == 8'h14) m_stat = m_stat & ~wdata[3:0];
      m_stat = m_stat | (m_hits & m_en[3:0]);
      if (m_hits[3] && m_wd) m_wdt = 1'b1;
      if (m_ld) m_cnt = wdata; else if (m_adv) m_cnt = m_nxt;
      if (wr) begin
        case (addr)
          8'h00, 8'h04, 8'h08, 8'h0C: m_match[addr[3:2]] = wdata;
          8'h1C: m_en = wdata[11:0];
          8'h18: if (wdata[0]) m_wd = 1'b1;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R4", {28'b0, irq}, {28'b0, m_stat});
      chk("R9", {31'b0, wdt}, {31'b0, m_wdt});
      chk("R10", {31'b0, rvalid}, {31'b0, m_rvalid});
      if (m_rvalid && rvalid) chk(rtag(m_raddr), rdata, m_rdata);
    end
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_checks++; n_err++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [31:0] v);
    rd = 1'b1; addr = a;
    @(negedge clk);
    v = rdata;
    rd = 1'b0;
  endtask

  logic [31:0] v;
  int          op;
  logic [7:0]  ra;
  logic [7:0]  amap [9] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18, 8'h1C, 8'h20};

  initial begin
    rst_n = 1'b0; tick = 1'b0; wr = 1'b0; rd = 1'b0; addr = 8'h00; wdata = 32'h0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R10 reset values and unmapped offset
    chk("R10 irq after reset", {28'b0, irq}, 32'h0);
    rd_reg(8'h10, v); chk("R10 counter reset", v, 32'h0);
    rd_reg(8'h1C, v); chk("R10 enable reset", v, 32'h0);
    wr_reg(8'h20, 32'hDEADBEEF);
    rd_reg(8'h20, v); chk("R10 unmapped", v, 32'h0);

    // R1 counting only while tick is high
    wr_reg(8'h10, 32'd50);
    tick = 1'b1; repeat (5) @(negedge clk); tick = 1'b0;
    rd_reg(8'h10, v); chk("R1 five ticks", v, 32'd55);

    // R2 load beats tick, counting resumes
    tick = 1'b1;
    wr_reg(8'h10, 32'd1000);
    rd_reg(8'h10, v); chk("R2 load wins", v, 32'd1000);
    tick = 1'b0;
    rd_reg(8'h10, v); chk("R2 resumes", v, 32'd1001);

    // R3 enabled channels latch, disabled channel does not
    wr_reg(8'h00, 32'd205); wr_reg(8'h04, 32'd203); wr_reg(8'h08, 32'd204);
    wr_reg(8'h1C, 32'h3); wr_reg(8'h10, 32'd200);
    tick = 1'b1; repeat (10) @(negedge clk); tick = 1'b0;
    chk("R3 gated status", {28'b0, irq}, 32'h3);
    rd_reg(8'h14, v); chk("R4 irq mirrors status", v, {28'b0, irq});

    // R5 partial clear, then clear colliding with a new event
    wr_reg(8'h14, 32'h2);
    chk("R5 partial clear", {28'b0, irq}, 32'h1);
    wr_reg(8'h10, 32'd300); wr_reg(8'h00, 32'd301);
    wr = 1'b1; addr = 8'h14; wdata = 32'h1; tick = 1'b1;
    @(negedge clk);
    wr = 1'b0; tick = 1'b0;
    chk("R5 set wins over clear", {31'b0, irq[0]}, 32'h1);
    wr_reg(8'h14, 32'h1);
    chk("R5 clear", {28'b0, irq}, 32'h0);

    // R6 upper enable bits dropped
    wr_reg(8'h1C, 32'hFFFFFFFF);
    rd_reg(8'h1C, v); chk("R6 enable width", v, 32'h00000FFF);
    wr_reg(8'h1C, 32'h3);

    // R7 match after wrap
    wr_reg(8'h10, 32'hFFFFFFFE); wr_reg(8'h00, 32'h1);
    tick = 1'b1; repeat (3) @(negedge clk); tick = 1'b0;
    chk("R7 wrap match", {28'b0, irq}, 32'h1);
    rd_reg(8'h10, v); chk("R7 wrapped count", v, 32'h1);

    // R8 watchdog enable set-only
    rd_reg(8'h18, v); chk("R8 initial", v, 32'h0);
    wr_reg(8'h18, 32'h0);
    rd_reg(8'h18, v); chk("R8 write zero", v, 32'h0);
    wr_reg(8'h18, 32'h1);
    rd_reg(8'h18, v); chk("R8 set", v, 32'h1);
    wr_reg(8'h18, 32'h0);
    rd_reg(8'h18, v); chk("R8 sticky", v, 32'h1);

    // R9 watchdog reset on channel 3 with its interrupt disabled
    wr_reg(8'h10, 32'd400); wr_reg(8'h0C, 32'd404);
    tick = 1'b1; repeat (3) @(negedge clk);
    chk("R9 not yet", {31'b0, wdt}, 32'h0);
    @(negedge clk); tick = 1'b0;
    chk("R9 raised", {31'b0, wdt}, 32'h1);
    chk("R9 irq3 still off", {31'b0, irq[3]}, 32'h0);
    repeat (3) @(negedge clk);
    chk("R9 held", {31'b0, wdt}, 32'h1);

    // R10 reset clears the watchdog state
    rst_n = 1'b0;
    @(negedge clk);
    chk("R10 wdt cleared", {31'b0, wdt}, 32'h0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    rd_reg(8'h18, v); chk("R10 wd enable cleared", v, 32'h0);

    // random phase scored by the model
    for (int n = 0; n < 4000; n++) begin
      tick = ($urandom_range(0, 3) != 0);
      op = $urandom_range(0, 9);
      ra = amap[$urandom_range(0, 8)];
      if (op < 3) begin
        wr = 1'b1; addr = ra;
        wdata = (ra <= 8'h10) ? 32'($urandom_range(0, 20)) : $urandom();
      end else if (op < 6) begin
        rd = 1'b1; addr = ra;
      end
      @(negedge clk);
      wr = 1'b0; rd = 1'b0;
    end
    tick = 1'b0;
    @(negedge clk);
    finish_run();
  end
endmodule